// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is a single input-capture channel for a general-purpose timer. It watches up to three raw timer pins. After synchronizing them, it either takes the first pin alone or the XOR of all three. The XOR setting suits the three position sensors of a brushless motor, because every sensor transition then gives the channel one edge. The resulting level goes through a digital glitch filter, a choice of active edge and an event divider. Each qualified event copies the running timer count into a capture register.

A capture sets a capture flag. If a capture arrives while that flag is still set, the register is overwritten with the newer count and an over-capture flag records that a value was lost. Each capture can also emit a one-cycle interrupt request pulse and a one-cycle DMA request pulse, each behind its own enable. Software clears the flags with clear strobes, and a read strobe on the capture register also clears the capture flag. The counter itself comes from outside the block as a free-running value.

Top module: `tcap_channel`

## Requirements
- R1: After reset, `cap_value` is 0, and `cap_flag`, `ovr_flag`, `irq_req` and `dma_req` are 0.
- R2: On a capture event, `cap_value` takes the value `counter` held during the event cycle, and `cap_flag` becomes 1.
- R3: A capture event while `cap_flag` is 1 still overwrites `cap_value` with the new counter value and sets `ovr_flag` to 1.
- R4: Each capture event produces a one-cycle pulse on `irq_req` when `irq_en` is 1, and no pulse when `irq_en` is 0.
- R5: Each capture event produces a one-cycle pulse on `dma_req` when `dma_en` is 1, and no pulse when `dma_en` is 0.
- R6: With `xor_sel` = 1, the channel level is `in_pins[0]` ^ `in_pins[1]` ^ `in_pins[2]`. With `xor_sel` = 0, it is `in_pins[0]` alone, and the other pins have no effect.
- R7: With `edge_pol` = 0, only rising edges of the channel level qualify. With `edge_pol` = 1, only falling edges qualify.
- R8: With `filt_sel` = F > 0, the filtered level follows a change only after F+1 consecutive synchronized samples that differ from it, so shorter pulses are dropped. With F = 0 the filter is bypassed and a one-cycle pulse passes.
- R9: `div_sel` codes 0, 1, 2 and 3 make a capture on every 1st, 2nd, 4th and 8th qualified edge. The edge count returns to 0 while `chan_en` is 0.
- R10: No capture event occurs while `chan_en` is 0.
- R11: A one-cycle pulse on `clr_cap_flag` or `rd_cap` clears `cap_flag`, and a pulse on `clr_ovr_flag` clears `ovr_flag`. A capture event in the same cycle wins, and the flag stays 1.
- R12: Each pin passes through a two-flop synchronizer. With the filter bypassed, a capture appears in `cap_flag` four clock edges after a pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_pins | input | 3 | Raw timer input pins, asynchronous |
| counter | input | 16 | Free-running timer count |
| chan_en | input | 1 | Channel capture enable |
| xor_sel | input | 1 | 1: XOR of all pins, 0: pin 0 only |
| edge_pol | input | 1 | 0: rising edge, 1: falling edge |
| filt_sel | input | 4 | Filter setting, 0 = bypass |
| div_sel | input | 2 | Event divider code |
| irq_en | input | 1 | Interrupt request enable |
| dma_en | input | 1 | DMA request enable |
| clr_cap_flag | input | 1 | Clear strobe for the capture flag |
| clr_ovr_flag | input | 1 | Clear strobe for the over-capture flag |
| rd_cap | input | 1 | Capture register read strobe |
| cap_value | output | 16 | Captured counter value |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Over-capture flag |
| irq_req | output | 1 | One-cycle interrupt request |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
The hardest condition to reach from the ports is a capture that coincides exactly with a flag-clear strobe. The capture moment is hidden behind the synchronizer, the filter and the edge register. The bench bypasses the filter and changes a pin on a falling clock edge. It then asserts the clear strobe on the cycle just before the fourth rising edge, which aligns the two inside the flag register. The divider reset on disable is reached with a second step: part of an eight-edge window is counted, the channel is disabled and re-enabled, and the bench then shows that seven further edges do not capture.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic {
    POL_RISE = 1'b0,
    POL_FALL = 1'b1
  } pol_e;

  // number of qualified edges per capture, minus one
  function automatic int unsigned div_quota(input int unsigned code);
    return (32'd1 << code) - 32'd1;
  endfunction

endpackage

// File: rtl/tcap_in_front.sv
module tcap_in_front #(
  parameter int NUM_PINS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins,
  input  logic                xor_sel,
  output logic                lvl
);

  logic [NUM_PINS-1:0] synced;

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_sync
      logic [SYNC_STAGES-1:0] stg;
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[SYNC_STAGES-2:0], pins[g]};
      end
      assign synced[g] = stg[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    if (xor_sel) lvl = ^synced;
    else         lvl = synced[0];
  end

endmodule

// File: rtl/tcap_glitch_filter.sv
module tcap_glitch_filter #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [FILT_W-1:0] setting,
  output logic              dout
);

  logic [FILT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= 1'b0;
      run_cnt <= '0;
    end else if (setting == '0) begin
      dout    <= din;
      run_cnt <= '0;
    end else if (din == dout) begin
      run_cnt <= '0;
    end else if (run_cnt >= setting) begin
      dout    <= din;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tcap_edge_div.sv
module tcap_edge_div
  import tcap_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl,
  input  logic             pol,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             cap_evt
);

  localparam int ECW = (1 << DIV_W) - 1;

  logic           prev;
  logic           qual;
  logic [ECW-1:0] ecnt;
  logic [ECW-1:0] quota;

  always_comb begin
    quota = ECW'(div_quota(32'(div)));
    if (pol == POL_FALL) qual = prev & ~lvl;
    else                 qual = lvl & ~prev;
    cap_evt = en & qual & (ecnt >= quota);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      ecnt <= '0;
    end else begin
      prev <= lvl;
      if (!en)
        ecnt <= '0;
      else if (qual)
        ecnt <= (ecnt >= quota) ? '0 : ecnt + 1'b1;
    end
  end

endmodule

// File: rtl/tcap_channel.sv
module tcap_channel #(
  parameter int NUM_PINS    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16,
  parameter int FILT_W      = 4,
  parameter int DIV_W       = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] in_pins,
  input  logic [CNT_W-1:0]    counter,
  input  logic                chan_en,
  input  logic                xor_sel,
  input  logic                edge_pol,
  input  logic [FILT_W-1:0]   filt_sel,
  input  logic [DIV_W-1:0]    div_sel,
  input  logic                irq_en,
  input  logic                dma_en,
  input  logic                clr_cap_flag,
  input  logic                clr_ovr_flag,
  input  logic                rd_cap,
  output logic [CNT_W-1:0]    cap_value,
  output logic                cap_flag,
  output logic                ovr_flag,
  output logic                irq_req,
  output logic                dma_req
);

  logic raw_lvl;
  logic filt_lvl;
  logic cap_evt;

  tcap_in_front #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_front (
    .clk     (clk),
    .rst     (rst),
    .pins    (in_pins),
    .xor_sel (xor_sel),
    .lvl     (raw_lvl)
  );

  tcap_glitch_filter #(
    .FILT_W (FILT_W)
  ) u_filt (
    .clk     (clk),
    .rst     (rst),
    .din     (raw_lvl),
    .setting (filt_sel),
    .dout    (filt_lvl)
  );

  tcap_edge_div #(
    .DIV_W (DIV_W)
  ) u_edge (
    .clk     (clk),
    .rst     (rst),
    .lvl     (filt_lvl),
    .pol     (edge_pol),
    .en      (chan_en),
    .div     (div_sel),
    .cap_evt (cap_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_value <= '0;
      cap_flag  <= 1'b0;
      ovr_flag  <= 1'b0;
      irq_req   <= 1'b0;
      dma_req   <= 1'b0;
    end else begin
      irq_req <= cap_evt & irq_en;
      dma_req <= cap_evt & dma_en;
      if (cap_evt) begin
        cap_value <= counter;
        cap_flag  <= 1'b1;
        if (cap_flag) ovr_flag <= 1'b1;
        else if (clr_ovr_flag) ovr_flag <= 1'b0;
      end else begin
        if (clr_cap_flag || rd_cap) cap_flag <= 1'b0;
        if (clr_ovr_flag)           ovr_flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tcap_channel_chk.sv
module tcap_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] counter,
  input logic             chan_en,
  input logic             irq_en,
  input logic             dma_en,
  input logic             clr_ovr_flag,
  input logic             cap_evt,
  input logic [CNT_W-1:0] cap_value,
  input logic             cap_flag,
  input logic             ovr_flag,
  input logic             irq_req,
  input logic             dma_req
);

  // R2
  cap_load_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (cap_flag && cap_value == $past(counter)));

  // R3
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && cap_flag) |=> ovr_flag);

  // R10
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !chan_en |-> !cap_evt);

  // R4
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(cap_evt && irq_en));

  // R5
  dma_src_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> $past(cap_evt && dma_en));

  // R11
  ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap_evt && !clr_ovr_flag) |=> $stable(ovr_flag));

endmodule

bind tcap_channel tcap_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .counter      (counter),
  .chan_en      (chan_en),
  .irq_en       (irq_en),
  .dma_en       (dma_en),
  .clr_ovr_flag (clr_ovr_flag),
  .cap_evt      (cap_evt),
  .cap_value    (cap_value),
  .cap_flag     (cap_flag),
  .ovr_flag     (ovr_flag),
  .irq_req      (irq_req),
  .dma_req      (dma_req)
);

// File: tb/tcap_channel_test.sv
`timescale 1ns/1ps
module tcap_channel_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  in_pins = '0;
  logic [15:0] counter = '0;
  logic        chan_en = 1'b0, xor_sel = 1'b0, edge_pol = 1'b0;
  logic [3:0]  filt_sel = '0;
  logic [1:0]  div_sel = '0;
  logic        irq_en = 1'b0, dma_en = 1'b0;
  logic        clr_cap_flag = 1'b0, clr_ovr_flag = 1'b0, rd_cap = 1'b0;
  logic [15:0] cap_value;
  logic        cap_flag, ovr_flag, irq_req, dma_req;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  int dma_seen = 0;

  always #2.5 clk = ~clk;

  tcap_channel uut (
    .clk(clk), .rst(rst), .in_pins(in_pins), .counter(counter),
    .chan_en(chan_en), .xor_sel(xor_sel), .edge_pol(edge_pol),
    .filt_sel(filt_sel), .div_sel(div_sel), .irq_en(irq_en), .dma_en(dma_en),
    .clr_cap_flag(clr_cap_flag), .clr_ovr_flag(clr_ovr_flag), .rd_cap(rd_cap),
    .cap_value(cap_value), .cap_flag(cap_flag), .ovr_flag(ovr_flag),
    .irq_req(irq_req), .dma_req(dma_req)
  );

  always @(negedge clk) begin
    if (!rst && irq_req) irq_seen++;
    if (!rst && dma_req) dma_seen++;
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic set_pins(input logic [2:0] v);
    @(negedge clk);
    in_pins = v;
    settle();
  endtask

  task automatic clear_flags();
    @(negedge clk);
    clr_cap_flag = 1'b1;
    clr_ovr_flag = 1'b1;
    @(negedge clk);
    clr_cap_flag = 1'b0;
    clr_ovr_flag = 1'b0;
  endtask

  task automatic pulse_pin0(input int width);
    @(negedge clk);
    in_pins[0] = 1'b1;
    repeat (width) @(negedge clk);
    in_pins[0] = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    check("R1 cap_value", cap_value, 0);
    check("R1 cap_flag", cap_flag, 0);
    check("R1 ovr_flag", ovr_flag, 0);
    check("R1 irq_req", irq_req, 0);
    check("R1 dma_req", dma_req, 0);
  endtask

  task automatic t_basic();
    chan_en = 1'b1; irq_en = 1'b1; dma_en = 1'b0;
    counter = 16'h1234;
    set_pins(3'b001);
    check("R2 value", cap_value, 16'h1234);
    check("R2 flag", cap_flag, 1);
    check("R3 no ovr", ovr_flag, 0);
    check("R4 irq once", irq_seen, 1);
    check("R5 no dma", dma_seen, 0);
    counter = 16'h5555;
    set_pins(3'b000);
    check("R7 falling ignored", cap_value, 16'h1234);
  endtask

  task automatic t_overcapture();
    counter = 16'h2222;
    set_pins(3'b001);
    check("R3 overwrite", cap_value, 16'h2222);
    check("R3 ovr set", ovr_flag, 1);
    @(negedge clk); clr_ovr_flag = 1'b1;
    @(negedge clk); clr_ovr_flag = 1'b0;
    check("R11 ovr clear", ovr_flag, 0);
    check("R11 cap kept", cap_flag, 1);
    @(negedge clk); clr_cap_flag = 1'b1;
    @(negedge clk); clr_cap_flag = 1'b0;
    check("R11 cap clear", cap_flag, 0);
    set_pins(3'b000);
    counter = 16'h3333;
    set_pins(3'b001);
    check("R2 recapture", cap_flag, 1);
    @(negedge clk); rd_cap = 1'b1;
    @(negedge clk); rd_cap = 1'b0;
    check("R11 read clears", cap_flag, 0);
    set_pins(3'b000);
  endtask

  task automatic t_dma();
    irq_en = 1'b0; dma_en = 1'b1;
    irq_seen = 0; dma_seen = 0;
    counter = 16'h0404;
    set_pins(3'b001);
    check("R5 dma once", dma_seen, 1);
    check("R4 irq off", irq_seen, 0);
    set_pins(3'b000);
    dma_en = 1'b0;
    clear_flags();
  endtask

  task automatic t_polarity();
    edge_pol = 1'b1;
    counter = 16'h0AAA;
    set_pins(3'b001);
    check("R7 rise ignored at pol 1", cap_flag, 0);
    counter = 16'h0BBB;
    set_pins(3'b000);
    check("R7 fall captured", cap_value, 16'h0BBB);
    check("R7 fall flag", cap_flag, 1);
    edge_pol = 1'b0;
    clear_flags();
  endtask

  task automatic t_xor();
    counter = 16'h0C0C;
    set_pins(3'b010);
    set_pins(3'b000);
    check("R6 pin1 ignored", cap_flag, 0);
    xor_sel = 1'b1;
    counter = 16'h0D0D;
    set_pins(3'b100);
    check("R6 pin2 via xor", cap_value, 16'h0D0D);
    clear_flags();
    set_pins(3'b110);
    check("R6 xor falls", cap_flag, 0);
    counter = 16'h0E0E;
    set_pins(3'b111);
    check("R6 three high", cap_value, 16'h0E0E);
    chan_en = 1'b0;
    set_pins(3'b000);
    xor_sel = 1'b0;
    chan_en = 1'b1;
    clear_flags();
  endtask

  task automatic t_filter();
    filt_sel = 4'd3;
    counter = 16'h0F01;
    pulse_pin0(3);
    check("R8 short pulse dropped", cap_flag, 0);
    counter = 16'h0F02;
    pulse_pin0(4);
    check("R8 long pulse passes", cap_value, 16'h0F02);
    clear_flags();
    filt_sel = 4'd0;
    counter = 16'h0F03;
    pulse_pin0(1);
    check("R8 bypass one cycle", cap_value, 16'h0F03);
    clear_flags();
  endtask

  task automatic t_divider();
    div_sel = 2'd2;
    for (int i = 1; i <= 3; i++) begin
      counter = 16'(i);
      pulse_pin0(2);
    end
    check("R9 div4 waits", cap_flag, 0);
    counter = 16'd4;
    pulse_pin0(2);
    check("R9 div4 fourth", cap_value, 4);
    clear_flags();
    div_sel = 2'd1;
    counter = 16'd21; pulse_pin0(2);
    check("R9 div2 first", cap_flag, 0);
    counter = 16'd22; pulse_pin0(2);
    check("R9 div2 second", cap_value, 22);
    clear_flags();
    div_sel = 2'd3;
    for (int i = 0; i < 5; i++) pulse_pin0(2);
    chan_en = 1'b0;
    repeat (3) @(negedge clk);
    chan_en = 1'b1;
    for (int i = 1; i <= 7; i++) begin
      counter = 16'(100 + i);
      pulse_pin0(2);
    end
    check("R9 reset on disable", cap_flag, 0);
    counter = 16'd108;
    pulse_pin0(2);
    check("R9 div8 eighth", cap_value, 108);
    div_sel = 2'd0;
    clear_flags();
  endtask

  task automatic t_enable();
    chan_en = 1'b0;
    counter = 16'h7777;
    pulse_pin0(2);
    check("R10 disabled", cap_flag, 0);
    chan_en = 1'b1;
  endtask

  task automatic t_race();
    counter = 16'h6161;
    @(negedge clk);
    in_pins[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 not yet", cap_flag, 0);
    clr_cap_flag = 1'b1;
    rd_cap = 1'b1;
    @(negedge clk);
    clr_cap_flag = 1'b0;
    rd_cap = 1'b0;
    check("R11 capture wins", cap_flag, 1);
    check("R12 four edges", cap_value, 16'h6161);
    set_pins(3'b000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_overcapture();
    t_dma();
    t_polarity();
    t_xor();
    t_filter();
    t_divider();
    t_enable();
    clear_flags();
    t_race();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule